// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. A clock divider feeds the timer. The timer's input clock is the system clock divided by four and then by a selectable prescale ratio of 1, 4 or 16. The timer counts from zero up to the value of the period input, then starts again. Each pass is one PWM period.

The requested duty cycle is 10 bits wide and arrives as 8 high bits and 2 low bits. The two low bits are compared against a sub-count taken from the divider chain. This gives the duty cycle four times the resolution of the timer. Software may change the duty inputs at any moment. The block copies them into a shadow register only at the end of a period, so a period never contains a mix of two duty values. The 8-bit high part of the shadow is visible on an output port.

Each period boundary raises the output and gives a single-cycle pulse that can serve as an interrupt-flag source. The output falls when the combined count reaches the shadowed duty value.

Top module: `pwm10_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pwm_o` and `match_o` are 0 and `duty_shadow_o` is 0.
- R2: With the timer running, one period lasts (period_i+1)×4×N system clocks. N is 1 for `presc_sel_i`=00, 4 for 01, and 16 for 10 and 11.
- R3: `match_o` is high for exactly one clock at each period boundary, and in no other cycle.
- R4: The duty value D is {duty_hi_i, duty_lo_i}, with duty_hi_i as bits 9:2. With PWM enabled, `pwm_o` rises in the cycle in which `match_o` is high and stays high for D×N clocks.
- R5: The duty inputs are sampled only at a period boundary. This includes a write made in the last clock before the boundary. A change takes effect in the next full period, and `duty_shadow_o` changes only in a cycle in which `match_o` is high.
- R6: A shadowed duty value of 0 keeps `pwm_o` low for the whole period.
- R7: If D ≥ (period_i+1)×4, `pwm_o` stays high for the whole period.
- R8: When `pwm_en_i` is 0, `pwm_o` is low one clock later and the shadow is not reloaded. After re-enable, `pwm_o` stays low until the next boundary, which reloads the shadow.
- R9: While `tmr_on_i` is 0, the timer and divider hold. No `match_o` pulse occurs and `pwm_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 8 | Last timer value of a period |
| duty_hi_i | input | 8 | Duty value bits 9:2 |
| duty_lo_i | input | 2 | Duty value bits 1:0 |
| tmr_on_i | input | 1 | Timer run enable |
| presc_sel_i | input | 2 | Prescale select: 00 → 1, 01 → 4, 1x → 16 |
| pwm_en_i | input | 1 | PWM output enable |
| pwm_o | output | 1 | PWM output, registered |
| match_o | output | 1 | One-clock period-boundary pulse |
| duty_shadow_o | output | 8 | High 8 bits of the shadowed duty value |

## Verification
At a period boundary, two events can fall on the same clock edge: the shadow reload and the output set/clear. A duty of zero makes the edge that sets the output also the edge that clears it. The bench checks that the output then never rises, and that a duty of one period minus one clock gives a single low clock. The bench also writes a new duty in the very last clock before a boundary and again in the first clock after one. Per-window high counts must show that the first write reaches the next period and the second waits a full period.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10,
    PS_DIV16B = 2'b11
  } presc_e;

  // Divider level: 0 -> /1, 1 -> /4, 2 -> /16
  function automatic int unsigned presc_level(presc_e sel);
    case (sel)
      PS_DIV1: return 0;
      PS_DIV4: return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/pwm10_clkdiv.sv
module pwm10_clkdiv
  import pwm10_pkg::*;
#(
  parameter int SUB_W  = 2,
  parameter int STEP_W = 2,
  parameter int LVLS   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [1:0]       sel_i,
  output logic             tick_o,
  output logic [SUB_W-1:0] sub_n_o
);
  localparam int DIV_W = SUB_W + STEP_W * (LVLS - 1);

  logic [DIV_W-1:0] div_q, div_n, mask;
  int unsigned      lvl;

  always_comb begin
    lvl  = presc_level(presc_e'(sel_i));
    mask = (DIV_W'(1) << (SUB_W + STEP_W * lvl)) - DIV_W'(1);
    tick_o = run_i && ((div_q & mask) == mask);
    if (!run_i)      div_n = div_q;
    else if (tick_o) div_n = '0;
    else             div_n = div_q + DIV_W'(1);
    // top SUB_W bits of the active divider width form the sub-count
    sub_n_o = SUB_W'(div_n >> (STEP_W * lvl));
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_n;
  end

  assert_div_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(div_q));
endmodule

// File: rtl/pwm10_timer.sv
module pwm10_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_n_o,
  output logic             wrap_o
);
  logic [TMR_W-1:0] tmr_q;

  always_comb begin
    wrap_o = tick_i && (tmr_q == period_i);
    if (!tick_i)     tmr_n_o = tmr_q;
    else if (wrap_o) tmr_n_o = '0;
    else             tmr_n_o = tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) tmr_q <= '0;
    else     tmr_q <= tmr_n_o;
  end

  assert_tmr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(tmr_q));
  assert_wrap_clear_R2: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (tmr_q == '0));
endmodule

// File: rtl/pwm10_duty_buf.sv
module pwm10_duty_buf #(
  parameter int HI_W = 8,
  parameter int LO_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrap_i,
  input  logic                 en_i,
  input  logic [HI_W-1:0]      hi_i,
  input  logic [LO_W-1:0]      lo_i,
  output logic [HI_W+LO_W-1:0] shadow_n_o,
  output logic [HI_W-1:0]      shadow_hi_o
);
  localparam int DUTY_W = HI_W + LO_W;

  logic [DUTY_W-1:0] shadow_q;

  always_comb begin
    if (wrap_i && en_i) shadow_n_o = {hi_i, lo_i};
    else                shadow_n_o = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) shadow_q <= '0;
    else     shadow_q <= shadow_n_o;
  end

  assign shadow_hi_o = shadow_q[DUTY_W-1 -: HI_W];

  assert_shadow_only_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(shadow_q));
  assert_shadow_frozen_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(shadow_q));
endmodule

// File: rtl/pwm10_out.sv
module pwm10_out #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  input  logic [CNT_W-1:0] shadow_n_i,
  output logic             pwm_o,
  output logic             match_o
);
  logic pwm_q, match_q, pwm_d, hit;

  always_comb begin
    // compare the count that will hold after this edge, so the
    // registered output falls exactly when the count reaches the duty
    hit   = (cnt_n_i == shadow_n_i);
    pwm_d = en_i && (wrap_i || pwm_q) && !hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pwm_q   <= pwm_d;
      match_q <= wrap_i;
    end
  end

  assign pwm_o   = pwm_q;
  assign match_o = match_q;

  assert_match_single_R3: assert property (@(posedge clk) disable iff (rst)
    match_q |=> !match_q);
  assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pwm_q);
  assert_rise_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> match_q);
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 2,
  parameter int STEP_W = 2,
  parameter int LVLS   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] period_i,
  input  logic [TMR_W-1:0] duty_hi_i,
  input  logic [SUB_W-1:0] duty_lo_i,
  input  logic             tmr_on_i,
  input  logic [1:0]       presc_sel_i,
  input  logic             pwm_en_i,
  output logic             pwm_o,
  output logic             match_o,
  output logic [TMR_W-1:0] duty_shadow_o
);
  localparam int CNT_W = TMR_W + SUB_W;

  logic             tick, wrap;
  logic [SUB_W-1:0] sub_n;
  logic [TMR_W-1:0] tmr_n;
  logic [CNT_W-1:0] shadow_n;

  pwm10_clkdiv #(.SUB_W(SUB_W), .STEP_W(STEP_W), .LVLS(LVLS)) u_div (
    .clk(clk), .rst(rst), .run_i(tmr_on_i), .sel_i(presc_sel_i),
    .tick_o(tick), .sub_n_o(sub_n)
  );

  pwm10_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .tick_i(tick), .period_i(period_i),
    .tmr_n_o(tmr_n), .wrap_o(wrap)
  );

  pwm10_duty_buf #(.HI_W(TMR_W), .LO_W(SUB_W)) u_buf (
    .clk(clk), .rst(rst), .wrap_i(wrap), .en_i(pwm_en_i),
    .hi_i(duty_hi_i), .lo_i(duty_lo_i),
    .shadow_n_o(shadow_n), .shadow_hi_o(duty_shadow_o)
  );

  pwm10_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .en_i(pwm_en_i), .wrap_i(wrap),
    .cnt_n_i({tmr_n, sub_n}), .shadow_n_i(shadow_n),
    .pwm_o(pwm_o), .match_o(match_o)
  );

  assert_no_match_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !tmr_on_i |=> !match_o);
endmodule

// File: tb/pwm10_gen_bench.sv
module pwm10_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] period_i = '0;
  logic [7:0] duty_hi_i = '0;
  logic [1:0] duty_lo_i = '0;
  logic       tmr_on_i = 1'b0;
  logic [1:0] presc_sel_i = '0;
  logic       pwm_en_i = 1'b0;
  logic       pwm_o, match_o;
  logic [7:0] duty_shadow_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pwm10_gen u_pwm10_gen (
    .clk(clk), .rst(rst), .period_i(period_i), .duty_hi_i(duty_hi_i),
    .duty_lo_i(duty_lo_i), .tmr_on_i(tmr_on_i), .presc_sel_i(presc_sel_i),
    .pwm_en_i(pwm_en_i), .pwm_o(pwm_o), .match_o(match_o),
    .duty_shadow_o(duty_shadow_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
  endfunction

  function automatic int exp_len(input int p, input logic [1:0] s);
    return (p + 1) * 4 * ratio_of(s);
  endfunction

  function automatic int exp_hi(input int d, input int p, input logic [1:0] s);
    int full = (p + 1) * 4;
    return ((d < full) ? d : full) * ratio_of(s);
  endfunction

  task automatic set_duty(input int d);
    logic [9:0] dv = d[9:0];
    duty_hi_i = dv[9:2];
    duty_lo_i = dv[1:0];
  endtask

  // advance to the next negedge at which match_o is high
  task automatic sync_match();
    int k = 0;
    @(negedge clk);
    while (!match_o && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  // called at a negedge where match_o is high; returns at the next such negedge
  task automatic run_window(output int len, output int hi, input int chg_at, input int new_d);
    len = 0;
    hi  = 0;
    do begin
      if (pwm_o) hi++;
      if (len == chg_at) set_duty(new_d);
      len++;
      @(negedge clk);
    end while (!match_o && len < 20000);
  endtask

  initial begin
    int len, hi, mcnt, pcnt;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_o == 1'b0, "R1 pwm after reset", int'(pwm_o), 0);
    chk(match_o == 1'b0, "R1 match after reset", int'(match_o), 0);
    chk(duty_shadow_o == 8'd0, "R1 shadow after reset", int'(duty_shadow_o), 0);

    // R9: timer stopped, nothing moves
    pwm_en_i = 1'b1;
    period_i = 8'd3;
    set_duty(5);
    mcnt = 0; pcnt = 0;
    repeat (200) begin
      @(negedge clk);
      if (match_o) mcnt++;
      if (pwm_o) pcnt++;
    end
    chk(mcnt == 0, "R9 no match while stopped", mcnt, 0);
    chk(pcnt == 0, "R9 pwm holds while stopped", pcnt, 0);
    chk(duty_shadow_o == 8'd0, "R9 shadow not loaded while stopped", int'(duty_shadow_o), 0);

    // R2/R4: basic period and duty at /1
    period_i = 8'd9; presc_sel_i = 2'b00; set_duty(17);
    tmr_on_i = 1'b1;
    sync_match();
    chk(duty_shadow_o == 8'd4, "R5 shadow loaded at boundary", int'(duty_shadow_o), 4);
    run_window(len, hi, -1, 0);
    chk(len == exp_len(9, 2'b00), "R2 period /1", len, exp_len(9, 2'b00));
    chk(hi == exp_hi(17, 9, 2'b00), "R4 high time /1", hi, exp_hi(17, 9, 2'b00));

    // R5: mid-period write waits for the boundary
    run_window(len, hi, 3, 30);
    chk(hi == 17, "R5 mid write not applied early", hi, 17);
    chk(duty_shadow_o == 8'd7, "R5 shadow after boundary", int'(duty_shadow_o), 7);
    // R5: write in the last clock before the boundary reaches the next period
    run_window(len, hi, 39, 6);
    chk(hi == 30, "R5 mid write applied next period", hi, 30);
    run_window(len, hi, 0, 0);
    chk(hi == 6, "R5 last-clock write applied", hi, 6);

    // R6: zero duty
    run_window(len, hi, 0, 39);
    chk(hi == 0, "R6 zero duty stays low", hi, 0);
    // duty one clock short of the period
    run_window(len, hi, 0, 40);
    chk(hi == 39, "R7 duty full-1 one low clock", hi, 39);
    // R7: duty equal to and above the period
    run_window(len, hi, 0, 1023);
    chk(hi == 40, "R7 duty equal period always high", hi, 40);
    run_window(len, hi, -1, 0);
    chk(hi == 40, "R7 duty above period always high", hi, 40);

    // R2/R4: prescale /4
    period_i = 8'd4; presc_sel_i = 2'b01; set_duty(7);
    sync_match();
    run_window(len, hi, -1, 0);
    chk(len == exp_len(4, 2'b01), "R2 period /4", len, exp_len(4, 2'b01));
    chk(hi == exp_hi(7, 4, 2'b01), "R4 high time /4", hi, exp_hi(7, 4, 2'b01));

    // R2/R4: prescale /16 via code 11
    period_i = 8'd2; presc_sel_i = 2'b11; set_duty(5);
    sync_match();
    run_window(len, hi, -1, 0);
    chk(len == exp_len(2, 2'b11), "R2 period /16 code 11", len, exp_len(2, 2'b11));
    chk(hi == exp_hi(5, 2, 2'b11), "R4 high time /16", hi, exp_hi(5, 2, 2'b11));

    // R8: disable forces low and freezes shadow
    pwm_en_i = 1'b0;
    set_duty(9);
    @(negedge clk);
    chk(pwm_o == 1'b0, "R8 low one clock after disable", int'(pwm_o), 0);
    sync_match();
    chk(duty_shadow_o == 8'd1, "R8 shadow held while disabled", int'(duty_shadow_o), 1);
    pwm_en_i = 1'b1;
    run_window(len, hi, -1, 0);
    chk(hi == 0, "R8 low until next boundary after enable", hi, 0);
    chk(duty_shadow_o == 8'd2, "R8 shadow reloaded after enable", int'(duty_shadow_o), 2);
    run_window(len, hi, -1, 0);
    chk(hi == exp_hi(9, 2, 2'b11), "R8 duty applied after enable", hi, exp_hi(9, 2, 2'b11));

    // R3: match pulse count over two periods
    mcnt = 0;
    for (int i = 0; i < 2 * exp_len(2, 2'b11); i++) begin
      if (match_o) mcnt++;
      @(negedge clk);
    end
    chk(mcnt == 2, "R3 one pulse per period", mcnt, 2);

    // random configurations
    for (int r = 0; r < 12; r++) begin
      int p = $urandom_range(0, 31);
      logic [1:0] s = 2'($urandom_range(0, 3));
      int d = $urandom_range(0, (p + 1) * 4 + 6);
      period_i = 8'(p); presc_sel_i = s; set_duty(d);
      sync_match();
      run_window(len, hi, -1, 0);
      chk(len == exp_len(p, s), "R2 random period", len, exp_len(p, s));
      chk(hi == exp_hi(d, p, s), "R4 random high time", hi, exp_hi(d, p, s));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule